// File: doc/BRIEF.md
# Parallel EEPROM Byte Access Controller

This block sits on the host side of a byte-wide parallel EEPROM and turns single-byte read and write commands into the chip-enable, output-enable and write-enable strobe sequences that the memory expects. The host issues one command at a time through a valid/ready port. The controller drives the address and data lines and the three active-low strobes. It returns one response per command, carrying the read byte and a status code. The data bus appears as separate output, output-enable and input vectors, and the pad buffer is left to the surrounding chip.

Every write is controlled by the write strobe. Output enable is raised and the data and address are set up before write enable falls. All three are held after write enable rises, and the data bus is then released. The controller then waits for the memory's internal programming cycle to end, using one of two methods chosen per command. In the first, it reads the written address repeatedly until bit 7 shows the true value. In the second, it watches the open-drain ready/busy line go low and then come back high. A timeout counter that starts when write enable falls ends the wait with a timeout status. Writes are refused for a fixed interval after reset while the memory powers up. All strobe widths, the access time, the busy window, the timeout and the power-up interval are counts of clock cycles set by parameters.

Top module: `eeprom_host_ctrl`

## Requirements
- R1: After reset, all three strobes (`ee_ce_n`, `ee_oe_n`, `ee_we_n`) are high, `ee_dq_oe` is low, `rsp_valid` is low and `cmd_ready` is high.
- R2: A read command (`cmd_write`=0) holds `ee_ce_n` and `ee_oe_n` low and `ee_we_n` high for exactly ACC_CYC cycles. It returns the byte on `ee_dq_in` from the last of those cycles in `rsp_rdata`, with status OK (2'b00). All strobes then return high.
- R3: During a write, `ee_ce_n` is low and `ee_oe_n` is high throughout. Address and data are driven for OES_CYC cycles before `ee_we_n` falls. `ee_we_n` stays low for exactly WP_CYC cycles, with address and data stable. Address and data stay driven for HOLD_CYC cycles after `ee_we_n` rises.
- R4: `ee_dq_oe` is high only while `ee_oe_n` is high. It has been low for at least one cycle before `ee_oe_n` falls.
- R5: In polling mode (`cmd_use_rdy`=0), the controller re-reads the written address after the write. Each read lasts ACC_CYC cycles, with one idle cycle between reads. It ends with status OK when `ee_dq_in[7]` equals bit 7 of the written byte.
- R6: In ready/busy mode (`cmd_use_rdy`=1), the controller allows up to TDB_CYC cycles for `ee_rdy_n` to go low. Once the line is low, the controller waits for it to go high again and then reports OK. If the line never goes low within that window, the controller reports OK at the end of the window.
- R7: If a write has not completed TMO_CYC cycles after `ee_we_n` fell, the response carries status TIMEOUT (2'b01) and all strobes are high.
- R8: For PWR_CYC cycles after reset, a write command is answered at once with status REFUSED (2'b10), and `ee_we_n` does not pulse. Read commands are served normally during that interval.
- R9: `cmd_ready` is low from the cycle after a command is accepted until the cycle in which `rsp_valid` is high. Exactly one one-cycle `rsp_valid` pulse follows each accepted command, and the status is never 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Controller idle and accepting a command |
| cmd_write | input | 1 | 1 = write byte, 0 = read byte |
| cmd_use_rdy | input | 1 | Completion method for writes: 1 = ready/busy line, 0 = bit-7 polling |
| cmd_addr | input | AW | Byte address |
| cmd_wdata | input | DW | Byte to write |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_status | output | 2 | 00 OK, 01 TIMEOUT, 10 REFUSED |
| rsp_rdata | output | DW | Byte from the last read phase |
| ee_ce_n | output | 1 | Chip enable, active low |
| ee_oe_n | output | 1 | Output enable, active low |
| ee_we_n | output | 1 | Write enable, active low |
| ee_addr | output | AW | Address lines |
| ee_dq_out | output | DW | Data bus value driven by the host |
| ee_dq_oe | output | 1 | Host drives the data bus when high |
| ee_dq_in | input | DW | Data bus value seen at the pads |
| ee_rdy_n | input | 1 | Ready/busy line, low while programming |

## Verification
The bench uses short timings so that every phase and wait fits in a short run: OES_CYC=2, WP_CYC=3, HOLD_CYC=2, ACC_CYC=3, TDB_CYC=4, TMO_CYC=300 and PWR_CYC=60. With a 60-cycle power-up interval, a write issued straight after reset is refused while a read is still served. A 300-cycle timeout lets the memory model's stuck-busy case trip the timeout in both completion modes. Ordinary busy times of up to 80 cycles, in random mixes, complete normally. Three-cycle strobes make the pulse-width, hold and bus-release ordering visible cycle by cycle.

// File: rtl/eeprom_host_pkg.sv
package eeprom_host_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_WR_GAP,
        ST_PL_READ,
        ST_PL_GAP,
        ST_RB_LOW,
        ST_RB_HIGH
    } ctl_state_e;

    localparam logic [1:0] RSP_OK      = 2'b00;
    localparam logic [1:0] RSP_TIMEOUT = 2'b01;
    localparam logic [1:0] RSP_REFUSED = 2'b10;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/eeprom_pwr_guard.sv
module eeprom_pwr_guard #(
    parameter int PWR_CYC = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    output logic pwr_ok
);
    localparam int PW = $clog2(PWR_CYC + 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
        logic          ok;
    } pwr_regs_t;

    pwr_regs_t pq, pd;

    always_comb begin
        pd = pq;
        if (pq.cnt == PW'(PWR_CYC)) begin
            pd.ok = 1'b1;
        end else begin
            pd.cnt = pq.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pq <= '0;
        end else begin
            pq <= pd;
        end
    end

    assign pwr_ok = pq.ok;
endmodule

// File: rtl/eeprom_tmo_watch.sv
module eeprom_tmo_watch #(
    parameter int TMO_CYC = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic clear,
    output logic expired
);
    localparam int TW = $clog2(TMO_CYC + 1);

    typedef struct packed {
        logic          armed;
        logic [TW-1:0] cnt;
    } tmo_regs_t;

    tmo_regs_t tq, td;

    always_comb begin
        td = tq;
        if (start) begin
            td.armed = 1'b1;
            td.cnt   = '0;
        end else if (clear) begin
            td.armed = 1'b0;
            td.cnt   = '0;
        end else if (tq.armed && (tq.cnt != TW'(TMO_CYC))) begin
            td.cnt = tq.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tq <= '0;
        end else begin
            tq <= td;
        end
    end

    assign expired = tq.armed && (tq.cnt == TW'(TMO_CYC));
endmodule

// File: rtl/eeprom_host_ctrl.sv
module eeprom_host_ctrl
    import eeprom_host_pkg::*;
#(
    parameter int AW       = 11,
    parameter int DW       = 8,
    parameter int OES_CYC  = 1,
    parameter int WP_CYC   = 8,
    parameter int HOLD_CYC = 1,
    parameter int ACC_CYC  = 11,
    parameter int TDB_CYC  = 4,
    parameter int TMO_CYC  = 500000,
    parameter int PWR_CYC  = 1000000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic          cmd_write,
    input  logic          cmd_use_rdy,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    output logic          rsp_valid,
    output logic [1:0]    rsp_status,
    output logic [DW-1:0] rsp_rdata,
    output logic          ee_ce_n,
    output logic          ee_oe_n,
    output logic          ee_we_n,
    output logic [AW-1:0] ee_addr,
    output logic [DW-1:0] ee_dq_out,
    output logic          ee_dq_oe,
    input  logic [DW-1:0] ee_dq_in,
    input  logic          ee_rdy_n
);
    localparam int PH_MAX = max_of(max_of(max_of(OES_CYC, WP_CYC), max_of(HOLD_CYC, ACC_CYC)), TDB_CYC);
    localparam int CW     = $clog2(PH_MAX + 1);
    localparam logic [CW-1:0] LD_OES  = CW'(OES_CYC - 1);
    localparam logic [CW-1:0] LD_WP   = CW'(WP_CYC - 1);
    localparam logic [CW-1:0] LD_HOLD = CW'(HOLD_CYC - 1);
    localparam logic [CW-1:0] LD_ACC  = CW'(ACC_CYC - 1);
    localparam logic [CW-1:0] LD_TDB  = CW'(TDB_CYC - 1);

    typedef struct packed {
        ctl_state_e    st;
        logic [CW-1:0] cnt;
        logic          use_rdy;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        logic          ce_n;
        logic          oe_n;
        logic          we_n;
        logic          dq_oe;
        logic          rsp_valid;
        logic [1:0]    rsp_status;
    } ctl_regs_t;

    localparam ctl_regs_t CTL_RESET = '{
        st: ST_IDLE, cnt: '0, use_rdy: 1'b0, addr: '0, wdata: '0, rdata: '0,
        ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0,
        rsp_valid: 1'b0, rsp_status: RSP_OK
    };

    ctl_regs_t q, d;
    logic      pwr_ok;
    logic      tmo_start;
    logic      tmo_expired;

    eeprom_pwr_guard #(.PWR_CYC(PWR_CYC)) u_pwr (
        .clk    (clk),
        .rst_n  (rst_n),
        .pwr_ok (pwr_ok)
    );

    eeprom_tmo_watch #(.TMO_CYC(TMO_CYC)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmo_start),
        .clear   (q.st == ST_IDLE),
        .expired (tmo_expired)
    );

    // next-state and strobe decode
    always_comb begin
        d           = q;
        d.rsp_valid = 1'b0;
        tmo_start   = 1'b0;

        unique case (q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    d.addr    = cmd_addr;
                    d.wdata   = cmd_wdata;
                    d.use_rdy = cmd_use_rdy;
                    if (!cmd_write) begin
                        d.st  = ST_RD_ACC;
                        d.cnt = LD_ACC;
                    end else if (!pwr_ok) begin
                        d.rsp_valid  = 1'b1;
                        d.rsp_status = RSP_REFUSED;
                    end else begin
                        d.st  = ST_WR_SETUP;
                        d.cnt = LD_OES;
                    end
                end
            end
            ST_RD_ACC: begin
                if (q.cnt == '0) begin
                    d.rdata      = ee_dq_in;
                    d.st         = ST_IDLE;
                    d.rsp_valid  = 1'b1;
                    d.rsp_status = RSP_OK;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_WR_SETUP: begin
                if (q.cnt == '0) begin
                    d.st      = ST_WR_PULSE;
                    d.cnt     = LD_WP;
                    tmo_start = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_WR_PULSE: begin
                if (q.cnt == '0) begin
                    d.st  = ST_WR_HOLD;
                    d.cnt = LD_HOLD;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_WR_HOLD: begin
                if (q.cnt == '0) begin
                    d.st = ST_WR_GAP;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_WR_GAP: begin
                if (q.use_rdy) begin
                    d.st  = ST_RB_LOW;
                    d.cnt = LD_TDB;
                end else begin
                    d.st  = ST_PL_READ;
                    d.cnt = LD_ACC;
                end
            end
            ST_PL_READ: begin
                if (q.cnt == '0) begin
                    d.rdata = ee_dq_in;
                    if (ee_dq_in[DW-1] == q.wdata[DW-1]) begin
                        d.st         = ST_IDLE;
                        d.rsp_valid  = 1'b1;
                        d.rsp_status = RSP_OK;
                    end else if (tmo_expired) begin
                        d.st         = ST_IDLE;
                        d.rsp_valid  = 1'b1;
                        d.rsp_status = RSP_TIMEOUT;
                    end else begin
                        d.st = ST_PL_GAP;
                    end
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_PL_GAP: begin
                d.st  = ST_PL_READ;
                d.cnt = LD_ACC;
            end
            ST_RB_LOW: begin
                if (!ee_rdy_n) begin
                    d.st = ST_RB_HIGH;
                end else if (tmo_expired) begin
                    d.st         = ST_IDLE;
                    d.rsp_valid  = 1'b1;
                    d.rsp_status = RSP_TIMEOUT;
                end else if (q.cnt == '0) begin
                    d.st         = ST_IDLE;
                    d.rsp_valid  = 1'b1;
                    d.rsp_status = RSP_OK;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_RB_HIGH: begin
                if (ee_rdy_n) begin
                    d.st         = ST_IDLE;
                    d.rsp_valid  = 1'b1;
                    d.rsp_status = RSP_OK;
                end else if (tmo_expired) begin
                    d.st         = ST_IDLE;
                    d.rsp_valid  = 1'b1;
                    d.rsp_status = RSP_TIMEOUT;
                end
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase

        // strobes follow the state being entered, so pins come straight from flops
        d.ce_n  = 1'b1;
        d.oe_n  = 1'b1;
        d.we_n  = 1'b1;
        d.dq_oe = 1'b0;
        unique case (d.st)
            ST_RD_ACC, ST_PL_READ: begin
                d.ce_n = 1'b0;
                d.oe_n = 1'b0;
            end
            ST_WR_SETUP, ST_WR_HOLD: begin
                d.ce_n  = 1'b0;
                d.dq_oe = 1'b1;
            end
            ST_WR_PULSE: begin
                d.ce_n  = 1'b0;
                d.we_n  = 1'b0;
                d.dq_oe = 1'b1;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= CTL_RESET;
        end else begin
            q <= d;
        end
    end

    assign cmd_ready  = (q.st == ST_IDLE);
    assign rsp_valid  = q.rsp_valid;
    assign rsp_status = q.rsp_status;
    assign rsp_rdata  = q.rdata;
    assign ee_ce_n    = q.ce_n;
    assign ee_oe_n    = q.oe_n;
    assign ee_we_n    = q.we_n;
    assign ee_addr    = q.addr;
    assign ee_dq_out  = q.wdata;
    assign ee_dq_oe   = q.dq_oe;
endmodule

// File: rtl/eeprom_host_chk.sv
module eeprom_host_chk #(
    parameter int AW     = 11,
    parameter int DW     = 8,
    parameter int WP_CYC = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce_n,
    input logic          oe_n,
    input logic          we_n,
    input logic          dq_oe,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] dq_out,
    input logic          cmd_ready,
    input logic          rsp_valid,
    input logic [1:0]    rsp_status,
    input logic          pwr_ok
);
    int we_low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_low_run <= 0;
        end else if (!we_n) begin
            we_low_run <= we_low_run + 1;
        end else begin
            we_low_run <= 0;
        end
    end

    AST_DQ_ONLY_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> oe_n);                                                    // R4
    AST_DQ_OFF_BEFORE_OE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe_n) |-> !$past(dq_oe));                                     // R4
    AST_WE_LOW_CONTEXT: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (oe_n && !ce_n && dq_oe));                                // R3
    AST_WE_LOW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && $past(!we_n)) |-> ($stable(addr) && $stable(dq_out)));    // R3
    AST_WE_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (we_low_run == WP_CYC));                            // R3
    AST_NO_WE_BEFORE_PWR: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |-> we_n);                                                  // R8
    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_status != 2'b11));                               // R9
    AST_READY_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (we_n && oe_n && ce_n && !dq_oe));                    // R9
endmodule

bind eeprom_host_ctrl eeprom_host_chk #(
    .AW     (AW),
    .DW     (DW),
    .WP_CYC (WP_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n       (ee_ce_n),
    .oe_n       (ee_oe_n),
    .we_n       (ee_we_n),
    .dq_oe      (ee_dq_oe),
    .addr       (ee_addr),
    .dq_out     (ee_dq_out),
    .cmd_ready  (cmd_ready),
    .rsp_valid  (rsp_valid),
    .rsp_status (rsp_status),
    .pwr_ok     (pwr_ok)
);

// File: tb/tb_eeprom_host_ctrl.sv
module tb_eeprom_host_ctrl;
    localparam int CLK_NS   = 10;
    localparam int AW       = 11;
    localparam int DW       = 8;
    localparam int OES_CYC  = 2;
    localparam int WP_CYC   = 3;
    localparam int HOLD_CYC = 2;
    localparam int ACC_CYC  = 3;
    localparam int TDB_CYC  = 4;
    localparam int TMO_CYC  = 300;
    localparam int PWR_CYC  = 60;
    localparam int STUCK    = 5000;

    localparam logic [1:0] S_OK  = 2'b00;
    localparam logic [1:0] S_TMO = 2'b01;
    localparam logic [1:0] S_REF = 2'b10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_NS/2) clk = ~clk;

    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic          cmd_write = 1'b0;
    logic          cmd_use_rdy = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic          rsp_valid;
    logic [1:0]    rsp_status;
    logic [DW-1:0] rsp_rdata;
    logic          ee_ce_n, ee_oe_n, ee_we_n, ee_dq_oe;
    logic [AW-1:0] ee_addr;
    logic [DW-1:0] ee_dq_out;
    logic [DW-1:0] ee_dq_in;
    logic          ee_rdy_n;

    eeprom_host_ctrl #(
        .AW(AW), .DW(DW), .OES_CYC(OES_CYC), .WP_CYC(WP_CYC), .HOLD_CYC(HOLD_CYC),
        .ACC_CYC(ACC_CYC), .TDB_CYC(TDB_CYC), .TMO_CYC(TMO_CYC), .PWR_CYC(PWR_CYC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_write(cmd_write), .cmd_use_rdy(cmd_use_rdy), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
        .rsp_rdata(rsp_rdata), .ee_ce_n(ee_ce_n), .ee_oe_n(ee_oe_n), .ee_we_n(ee_we_n),
        .ee_addr(ee_addr), .ee_dq_out(ee_dq_out), .ee_dq_oe(ee_dq_oe),
        .ee_dq_in(ee_dq_in), .ee_rdy_n(ee_rdy_n)
    );

    // memory model
    logic [DW-1:0] mem [2**AW];
    logic [DW-1:0] shadow [2**AW];
    int            busy_left = 0;
    int            busy_since = 0;
    int            next_busy = 0;
    int            wr_seen = 0;
    logic [AW-1:0] busy_addr = '0;
    logic          we_seen = 1'b1;

    always @(negedge clk) begin
        we_seen <= ee_we_n;
        if (!rst_n) begin
            for (int i = 0; i < 2**AW; i++) mem[i] <= DW'(i) ^ 8'h5A;
            busy_left <= 0;
        end else if (!we_seen && ee_we_n && !ee_ce_n) begin
            mem[ee_addr] <= ee_dq_out;
            busy_left    <= next_busy;
            busy_since   <= 0;
            busy_addr    <= ee_addr;
            wr_seen      <= wr_seen + 1;
        end else if (busy_left > 0) begin
            busy_left  <= busy_left - 1;
            busy_since <= busy_since + 1;
        end
    end

    assign ee_dq_in = (!ee_ce_n && !ee_oe_n)
                    ? ((busy_left > 0 && ee_addr == busy_addr)
                       ? {~mem[ee_addr][DW-1], 7'h2A} : mem[ee_addr])
                    : '0;
    assign ee_rdy_n = !(busy_left > 0 && busy_since >= 2);

    // protocol monitors
    int nchk = 0, nbad = 0, ncmd = 0, nrsp = 0, cyc = 0;
    int clash = 0, we_run = 0, we_bad = 0, oe_run = 0, last_oe_run = 0, ready_bad = 0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n) begin
            if (rsp_valid) nrsp = nrsp + 1;
            if (ee_dq_oe && !ee_oe_n) clash = clash + 1;
            if (!ee_we_n) we_run = we_run + 1;
            else begin
                if (we_run != 0 && we_run != WP_CYC) we_bad = we_bad + 1;
                we_run = 0;
            end
            if (!ee_oe_n) oe_run = oe_run + 1;
            else begin
                if (oe_run != 0) last_oe_run = oe_run;
                oe_run = 0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_wr_status(input int busy);
        return (busy >= TMO_CYC) ? S_TMO : S_OK;
    endfunction

    task automatic run_cmd(input bit w, input bit use_rdy, input logic [AW-1:0] a,
                           input logic [DW-1:0] dat, input int busy,
                           output logic [1:0] st, output logic [DW-1:0] rd);
        int guard;
        next_busy = busy;
        guard = 0;
        while (!cmd_ready && guard < 1000) begin @(negedge clk); guard++; end
        cmd_valid   = 1'b1;
        cmd_write   = w;
        cmd_use_rdy = use_rdy;
        cmd_addr    = a;
        cmd_wdata   = dat;
        @(negedge clk);
        cmd_valid = 1'b0;
        ncmd++;
        guard = 0;
        while (!rsp_valid && guard < 20000) begin
            if (cmd_ready) ready_bad++;
            @(negedge clk);
            guard++;
        end
        st = rsp_status;
        rd = rsp_rdata;
        if (w && st != S_REF) shadow[a] = dat;
    endtask

    task automatic do_write(input string req, input bit use_rdy, input logic [AW-1:0] a,
                            input logic [DW-1:0] dat, input int busy);
        logic [1:0]    st;
        logic [DW-1:0] rd;
        run_cmd(1'b1, use_rdy, a, dat, busy, st, rd);
        check(st == exp_wr_status(busy), req, "write status", st, exp_wr_status(busy));
        if (st == S_OK) check(busy_left == 0, req, "done before busy end", busy_left, 0);
        if (busy >= TMO_CYC) begin
            check(ee_ce_n && ee_oe_n && ee_we_n, "R7", "strobes after timeout",
                  {ee_ce_n, ee_oe_n, ee_we_n}, 3'b111);
            while (busy_left > 0) @(negedge clk);
            @(negedge clk);
        end
    endtask

    task automatic do_read(input string req, input logic [AW-1:0] a);
        logic [1:0]    st;
        logic [DW-1:0] rd;
        run_cmd(1'b0, 1'b0, a, '0, 0, st, rd);
        check(st == S_OK, req, "read status", st, S_OK);
        check(rd == shadow[a], req, "read data", rd, shadow[a]);
        @(negedge clk);
        check(last_oe_run == ACC_CYC, "R2", "read strobe width", last_oe_run, ACC_CYC);
    endtask

    initial begin
        logic [1:0]    st;
        logic [DW-1:0] rd;
        int            w0;
        void'($urandom(32'd20240));
        for (int i = 0; i < 2**AW; i++) shadow[i] = DW'(i) ^ 8'h5A;
        repeat (4) @(negedge clk);
        // R1 reset state
        check(ee_ce_n && ee_oe_n && ee_we_n && !ee_dq_oe, "R1", "strobes in reset",
              {ee_ce_n, ee_oe_n, ee_we_n, ee_dq_oe}, 4'b1110);
        check(!rsp_valid, "R1", "rsp_valid in reset", rsp_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_ready, "R1", "ready after reset", cmd_ready, 1);

        // R8 refusal during power-up, reads still served
        w0 = wr_seen;
        run_cmd(1'b1, 1'b0, 11'h005, 8'hC3, 0, st, rd);
        check(st == S_REF, "R8", "early write status", st, S_REF);
        repeat (3) @(negedge clk);
        check(wr_seen == w0, "R8", "no WE pulse while refused", wr_seen, w0);
        do_read("R8", 11'h005);
        repeat (PWR_CYC + 10) @(negedge clk);

        // R5 polling directed
        do_write("R5", 1'b0, 11'h010, 8'h80, 0);
        do_read("R5", 11'h010);
        do_write("R5", 1'b0, 11'h011, 8'h7F, 50);
        do_read("R5", 11'h011);
        // R6 ready/busy directed
        do_write("R6", 1'b1, 11'h7FF, 8'hA5, 40);
        do_read("R6", 11'h7FF);
        do_write("R6", 1'b1, 11'h000, 8'h3C, 0);
        do_read("R6", 11'h000);
        // R7 timeouts in both modes
        do_write("R7", 1'b0, 11'h123, 8'h99, STUCK);
        do_write("R7", 1'b1, 11'h124, 8'h11, STUCK);
        do_read("R7", 11'h123);

        // random mix
        for (int k = 0; k < 60; k++) begin
            logic [AW-1:0] a;
            a = AW'($urandom_range(0, 2**AW - 1));
            if ($urandom_range(0, 1) == 1)
                do_write("R3", 1'($urandom_range(0, 1)), a, DW'($urandom_range(0, 255)),
                         int'($urandom_range(0, 80)));
            else
                do_read("R2", a);
        end

        check(clash == 0, "R4", "bus driven with OE low", clash, 0);
        check(we_bad == 0, "R3", "WE pulse width errors", we_bad, 0);
        check(ready_bad == 0, "R9", "ready while busy", ready_bad, 0);
        check(nrsp == ncmd, "R9", "responses per command", nrsp, ncmd);
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        while (cyc < 190000) @(negedge clk);
        nchk++;
        nbad++;
        $display("FAIL R9 watchdog actual=%0d expected=%0d", cyc, 190000);
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule